// File: doc/BRIEF.md
# Disk Channel Interrupt Cause Register Block

This block gathers the two interrupt sources of a disk channel, a device interrupt and a DMA bus error, into one small register set. It drives a single interrupt line. Each source is a single-cycle pulse that sets a sticky cause bit. Software reads the causes, enables them, and clears them by writing ones. When a bus error occurs, the block captures the 64-bit faulting bus address and holds it in two read-only words, so the failing transfer can be located after the fact.

A read of the device status word also acknowledges the device. If the status value shows the device is not busy, that read clears the pending device-interrupt cause. Software can therefore service the device without a separate clear write. The register port is a word-addressed bus with separate read and write strobes. Read data is registered and appears in the cycle after the read strobe.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset, the cause bits, the enable bits, the captured error address, `irq` and `bus_rdata` are all zero.
- R2: A `dev_irq` pulse sets cause bit 0 and a `dma_err` pulse sets cause bit 1. Both bits are sticky and are read in bits [1:0] of word index 3, with the upper bits zero.
- R3: A write to word index 7 clears every cause bit whose data bit is 1 and leaves the others unchanged. Writing 0x03 clears both.
- R4: If a cause pulse arrives in the same cycle as any clear of that bit, the bit ends up set.
- R5: A write to word index 5 ORs data bits [1:0] into the enable bits. Reading word index 5 returns the enable bits.
- R6: `irq` is 1 exactly when some cause bit is 1 and its enable bit is also 1.
- R7: A `dma_err` pulse that arrives while cause bit 1 is clear captures `dma_err_addr`. Its low 32 bits read at word index 0 and its high 32 bits read at word index 1.
- R8: While cause bit 1 stays set, later bus errors do not change the captured address. A new error in the same cycle as the clear of bit 1 is captured.
- R9: A read of word index 8 returns `dev_status` in bits [7:0]. If bit 7 of `dev_status` is 0, that read clears cause bit 0. If bit 7 is 1, the read leaves cause bit 0 unchanged.
- R10: Read data appears on `bus_rdata` one cycle after `bus_rd` and is zero in a cycle that follows no read. Unmapped word indices read as zero. Writes to word indices 0, 1, 3 and 8 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word index of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dev_irq | input | 1 | Device interrupt pulse |
| dma_err | input | 1 | DMA bus error pulse |
| dma_err_addr | input | 64 | Faulting bus address, valid with `dma_err` |
| dev_status | input | 8 | Current device status value, bit 7 = busy |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that `dma_err_addr` matters only in cycles where `dma_err` is high. The stimulus drives one bus access at a time and changes the error address only together with an error pulse. The stimulus also places a device pulse on the same edge as a clear write, and a bus error on the same edge as the clear of the error bit, because these coincidences exercise the set-wins rule and re-arming of the capture. The status-read acknowledge is driven once with the busy bit set and once with it clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int CAUSE_W   = 2;
    localparam int CAUSE_DEV = 0;
    localparam int CAUSE_ERR = 1;

    localparam int IDX_ERR_LO = 0;
    localparam int IDX_ERR_HI = 1;
    localparam int IDX_CAUSE  = 3;
    localparam int IDX_ENSET  = 5;
    localparam int IDX_CLEAR  = 7;
endpackage

// File: rtl/irqc_cause.sv
module irqc_cause
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] set_i,
    input  logic [CAUSE_W-1:0] clr_i,
    input  logic [CAUSE_W-1:0] en_set_i,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [CAUSE_W-1:0] en_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
        logic [CAUSE_W-1:0] en;
        logic               irq;
    } st_t;

    st_t st_d, st_q;
    logic [CAUSE_W-1:0] cause_nxt;

    for (genvar i = 0; i < CAUSE_W; i++) begin : g_bit
        assign cause_nxt[i] = set_i[i] | (st_q.cause[i] & ~clr_i[i]);
    end

    always_comb begin
        st_d       = st_q;
        st_d.cause = cause_nxt;
        st_d.en    = st_q.en | en_set_i;
        st_d.irq   = |(cause_nxt & st_d.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_o = st_q.cause;
    assign en_o    = st_q.en;
    assign irq_o   = st_q.irq;
endmodule

// File: rtl/irqc_errcap.sv
module irqc_errcap #(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          err_i,
    input  logic          held_i,
    input  logic          rearm_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_o
);
    typedef struct packed {
        logic [AW-1:0] addr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (err_i && (!held_i || rearm_i))
            st_d.addr = addr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.addr;
endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux
    import irqc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int STAT_W    = 8,
    parameter int DSTAT_IDX = 8,
    localparam int EADDR_W  = 2 * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [EADDR_W-1:0] err_addr_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [CAUSE_W-1:0] en_i,
    input  logic [STAT_W-1:0]  dstat_i,
    output logic [DATA_W-1:0]  rdata_o
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.rdata = '0;
        if (rd_i) begin
            if (addr_i == ADDR_W'(IDX_ERR_LO))
                st_d.rdata = err_addr_i[DATA_W-1:0];
            else if (addr_i == ADDR_W'(IDX_ERR_HI))
                st_d.rdata = err_addr_i[EADDR_W-1:DATA_W];
            else if (addr_i == ADDR_W'(IDX_CAUSE))
                st_d.rdata = DATA_W'(cause_i);
            else if (addr_i == ADDR_W'(IDX_ENSET))
                st_d.rdata = DATA_W'(en_i);
            else if (addr_i == ADDR_W'(DSTAT_IDX))
                st_d.rdata = DATA_W'(dstat_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
    import irqc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int STAT_W    = 8,
    parameter int BUSY_BIT  = 7,
    parameter int DSTAT_IDX = 8,
    localparam int EADDR_W  = 2 * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               dev_irq,
    input  logic               dma_err,
    input  logic [EADDR_W-1:0] dma_err_addr,
    input  logic [STAT_W-1:0]  dev_status,
    output logic               irq
);
    logic [CAUSE_W-1:0] cause_q, en_q, set_v, clr_v, en_set_v;
    logic [EADDR_W-1:0] err_addr_q;
    logic               wr_clr, wr_en, rd_stat;
    logic               unused_wdata_hi;

    assign wr_clr  = bus_wr && (bus_addr == ADDR_W'(IDX_CLEAR));
    assign wr_en   = bus_wr && (bus_addr == ADDR_W'(IDX_ENSET));
    assign rd_stat = bus_rd && (bus_addr == ADDR_W'(DSTAT_IDX));
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CAUSE_W];

    always_comb begin
        set_v            = '0;
        set_v[CAUSE_DEV] = dev_irq;
        set_v[CAUSE_ERR] = dma_err;
        clr_v            = wr_clr ? bus_wdata[CAUSE_W-1:0] : '0;
        if (rd_stat && !dev_status[BUSY_BIT])
            clr_v[CAUSE_DEV] = 1'b1;
        en_set_v         = wr_en ? bus_wdata[CAUSE_W-1:0] : '0;
    end

    irqc_cause u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_v),
        .clr_i    (clr_v),
        .en_set_i (en_set_v),
        .cause_o  (cause_q),
        .en_o     (en_q),
        .irq_o    (irq)
    );

    irqc_errcap #(.AW(EADDR_W)) u_errcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_i   (dma_err),
        .held_i  (cause_q[CAUSE_ERR]),
        .rearm_i (clr_v[CAUSE_ERR]),
        .addr_i  (dma_err_addr),
        .addr_o  (err_addr_q)
    );

    irqc_rdmux #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .STAT_W    (STAT_W),
        .DSTAT_IDX (DSTAT_IDX)
    ) u_rdmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (bus_rd),
        .addr_i     (bus_addr),
        .err_addr_i (err_addr_q),
        .cause_i    (cause_q),
        .en_i       (en_q),
        .dstat_i    (dev_status),
        .rdata_o    (bus_rdata)
    );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int STAT_W    = 8,
    parameter int BUSY_BIT  = 7,
    parameter int DSTAT_IDX = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic                  dev_irq,
    input logic                  dma_err,
    input logic [STAT_W-1:0]     dev_status,
    input logic                  irq,
    input logic [CAUSE_W-1:0]    cause_q,
    input logic [CAUSE_W-1:0]    en_q,
    input logic [2*DATA_W-1:0]   err_addr_q
);
    logic clr_err_wr, clr_dev_wr;
    assign clr_err_wr = bus_wr && bus_addr == ADDR_W'(IDX_CLEAR) && bus_wdata[CAUSE_ERR];
    assign clr_dev_wr = bus_wr && bus_addr == ADDR_W'(IDX_CLEAR) && bus_wdata[CAUSE_DEV];

    p_dev_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dev_irq |=> cause_q[CAUSE_DEV]);
    p_err_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dma_err |=> cause_q[CAUSE_ERR]);
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err_wr && !dma_err) |=> !cause_q[CAUSE_ERR]);
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_dev_wr && dev_irq) |=> cause_q[CAUSE_DEV]);
    p_en_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((en_q & $past(en_q)) == $past(en_q)));
    p_irq_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cause_q != '0));
    p_addr_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q[CAUSE_ERR] && !clr_err_wr) |=> $stable(err_addr_q));
    p_busy_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(DSTAT_IDX) && dev_status[BUSY_BIT]
         && cause_q[CAUSE_DEV] && !bus_wr) |=> cause_q[CAUSE_DEV]);
endmodule

bind irq_cause_ctrl irqc_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .STAT_W    (STAT_W),
    .BUSY_BIT  (BUSY_BIT),
    .DSTAT_IDX (DSTAT_IDX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .dev_irq    (dev_irq),
    .dma_err    (dma_err),
    .dev_status (dev_status),
    .irq        (irq),
    .cause_q    (cause_q),
    .en_q       (en_q),
    .err_addr_q (err_addr_q)
);

// File: tb/irq_cause_ctrl_test.sv
module irq_cause_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dev_irq = 1'b0, dma_err = 1'b0;
    logic [63:0] dma_err_addr = '0;
    logic [7:0]  dev_status = '0;
    logic        irq;

    int checks = 0, fails = 0, cycles = 0;
    string phase = "R1 reset";

    // reference model state
    bit        m_dev, m_err, m_en0, m_en1;
    bit [63:0] m_addr;
    bit [31:0] m_rdata;

    always #2.5 clk = ~clk;

    irq_cause_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_irq(dev_irq), .dma_err(dma_err), .dma_err_addr(dma_err_addr),
        .dev_status(dev_status), .irq(irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dev = 0; m_err = 0; m_en0 = 0; m_en1 = 0; m_addr = 0; m_rdata = 0;
        end else begin
            bit clr_dev, clr_err;
            m_rdata = 0;
            if (bus_rd) begin
                case (int'(bus_addr))
                    0: m_rdata = m_addr[31:0];
                    1: m_rdata = m_addr[63:32];
                    3: m_rdata = {30'd0, m_err, m_dev};
                    5: m_rdata = {30'd0, m_en1, m_en0};
                    8: m_rdata = {24'd0, dev_status};
                    default: m_rdata = 0;
                endcase
            end
            clr_dev = bus_wr && bus_addr == 7 && bus_wdata[0];
            clr_err = bus_wr && bus_addr == 7 && bus_wdata[1];
            if (bus_rd && bus_addr == 8 && !dev_status[7]) clr_dev = 1;
            if (dma_err && (!m_err || clr_err)) m_addr = dma_err_addr;
            m_dev = dev_irq || (m_dev && !clr_dev);
            m_err = dma_err || (m_err && !clr_err);
            if (bus_wr && bus_addr == 5) begin
                m_en0 = m_en0 | bus_wdata[0];
                m_en1 = m_en1 | bus_wdata[1];
            end
        end
    end

    always @(negedge clk) begin
        bit exp_irq;
        cycles++;
        exp_irq = (m_dev && m_en0) || (m_err && m_en1);
        checks++;
        if (bus_rdata !== m_rdata) begin
            fails++;
            $display("FAIL %s: bus_rdata actual %h expected %h", phase, bus_rdata, m_rdata);
        end
        checks++;
        if (irq !== exp_irq) begin
            fails++;
            $display("FAIL %s: irq actual %b expected %b", phase, irq, exp_irq);
        end
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic rd(logic [3:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic pulse(bit d, bit e, logic [63:0] ad);
        @(negedge clk);
        dev_irq = d; dma_err = e; dma_err_addr = ad;
        @(negedge clk);
        dev_irq = 0; dma_err = 0;
    endtask

    initial begin
        idle(3);
        rd(4'd3); rd(4'd5); rd(4'd0); rd(4'd1);
        rst_n = 1;
        phase = "R1 after release";
        rd(4'd3); rd(4'd0); idle(2);

        phase = "R5 enable set";
        wr(4'd5, 32'h1); rd(4'd5);

        phase = "R2 device pulse";
        pulse(1, 0, 64'h0); rd(4'd3); idle(2);

        phase = "R6 masked error";
        wr(4'd7, 32'h1);
        pulse(0, 1, 64'hDEAD_BEEF_0123_4567); rd(4'd3); idle(2);

        phase = "R7 address capture";
        rd(4'd0); rd(4'd1);

        phase = "R8 address frozen";
        pulse(0, 1, 64'h1111_2222_3333_4444); rd(4'd0); rd(4'd1);

        phase = "R3 partial clear";
        pulse(1, 0, 64'h0);
        wr(4'd7, 32'h2); rd(4'd3);
        pulse(0, 1, 64'hAAAA_0000_5555_FFFF); rd(4'd0); rd(4'd1);

        phase = "R5 init write 0x03";
        wr(4'd5, 32'h3); rd(4'd5); idle(2);

        phase = "R4 set wins over clear";
        @(negedge clk);
        bus_addr = 4'd7; bus_wdata = 32'h3; bus_wr = 1; dev_irq = 1;
        @(negedge clk);
        bus_wr = 0; dev_irq = 0; bus_wdata = 0;
        rd(4'd3);

        phase = "R8 rearm on clear";
        pulse(0, 1, 64'h0F0F_0F0F_F0F0_F0F0);
        @(negedge clk);
        bus_addr = 4'd7; bus_wdata = 32'h2; bus_wr = 1;
        dma_err = 1; dma_err_addr = 64'h7777_6666_5555_4444;
        @(negedge clk);
        bus_wr = 0; dma_err = 0; bus_wdata = 0;
        rd(4'd0); rd(4'd1); rd(4'd3);

        phase = "R9 busy status read";
        dev_status = 8'h80; rd(4'd8); rd(4'd3);
        phase = "R9 idle status read";
        dev_status = 8'h50; rd(4'd8); rd(4'd3);
        @(negedge clk);
        bus_addr = 4'd8; bus_rd = 1; dev_irq = 1;
        @(negedge clk);
        bus_rd = 0; dev_irq = 0;
        rd(4'd3);

        phase = "R10 unmapped and read-only";
        rd(4'd2); rd(4'd4); rd(4'd15);
        wr(4'd3, 32'h0); wr(4'd0, 32'hFFFF_FFFF); wr(4'd1, 32'h1234);
        wr(4'd8, 32'h0);
        rd(4'd3); rd(4'd0); rd(4'd1);
        wr(4'd7, 32'h3); rd(4'd3); idle(3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule